// File: doc/BRIEF.md
# Interrupt Status and Force-Event Unit

This block gathers single-cycle event pulses from the command engine, the data engine, the DMA engine and the card-detect input of a storage card host controller, and keeps each one in a sticky 32-bit status vector until software clears it. Two masks act in turn. The recording mask decides which events may set a status bit. The signalling mask decides which recorded bits may raise the single interrupt line. Software clears bits by writing ones, and it can inject error and card-interrupt events through a one-shot force write. Injected events take the same path as events from the hardware.

The card-detect level is synchronised inside the block. Its rising and falling edges become the insertion and removal events. Three grouped summaries give the command-error, data-error and any-error state of the recorded vector.

Top module: `irq_status_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, status_o, masked_o, irq_o and the three summaries read zero until an event is recorded.
- R2: The status bit map is fixed: 0 command done, 1 transfer done, 2 block gap, 3 DMA interrupt, 4 write buffer ready, 5 read buffer ready, 6 card inserted, 7 card removed, 8 card interrupt, 16 command timeout, 17 command CRC, 18 command end bit, 19 command index, 20 data timeout, 21 data CRC, 22 data end bit, 24 auto-stop command error, 28 DMA error. All other bits always read 0, and evt_i pulses on those bits are ignored.
- R3: An evt_i pulse sets its status bit at the next clock edge only if the same bit of stat_en_i is 1. Otherwise the status bit does not change.
- R4: A set status bit stays set until a clear write (clr_we_i high) has a 1 in that position of clr_data_i. Zeros in clr_data_i leave bits unchanged.
- R5: When a recorded event and a clear hit the same bit in the same cycle, the bit stays set.
- R6: masked_o equals status_o AND sig_en_i without delay, and irq_o is high exactly when masked_o is non-zero.
- R7: cmd_err_o is the OR of status bits 16 to 19. data_err_o is the OR of bits 20, 21, 22 and 24. any_err_o is cmd_err_o OR data_err_o OR bit 28.
- R8: A cycle with force_we_i high sets each status bit named in force_data_i among bits 8, 16 to 22, 24 and 28, subject to stat_en_i. Other force bits are ignored. The force acts in that cycle only and is not kept.
- R9: With two synchroniser stages, a rising edge of cd_i sets bit 6 and a falling edge sets bit 7 at the third clock edge after the change (subject to stat_en_i). evt_i bits 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses from the command, data and DMA engines |
| cd_i | input | 1 | Asynchronous card-detect level |
| stat_en_i | input | 32 | Recording mask |
| sig_en_i | input | 32 | Signalling mask |
| clr_we_i | input | 1 | Clear write strobe |
| clr_data_i | input | 32 | Write-one-to-clear data |
| force_we_i | input | 1 | Force write strobe |
| force_data_i | input | 32 | Events to inject |
| status_o | output | 32 | Sticky status vector |
| masked_o | output | 32 | Status ANDed with the signalling mask |
| irq_o | output | 1 | Interrupt request |
| cmd_err_o | output | 1 | Any command error recorded |
| data_err_o | output | 1 | Any data error recorded |
| any_err_o | output | 1 | Any error recorded |

## Verification
Random mixes of event pulses, both masks, clear words and force words are applied together. This mix tells set-wins-over-clear apart from clear-wins, and a recording-mask gate apart from a signalling-mask gate. Directed patterns drive every evt_i bit at once to expose reserved and card-detect positions that should not record, and drive an all-ones force word to show which bits can be injected and that the force does not persist. Card-detect toggles are sampled on each clock edge after the change, so a synchroniser with too few or too many stages shows up as an early or late insertion bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAT_W = 32;

  localparam int B_CARD_INS = 6;
  localparam int B_CARD_REM = 7;
  localparam int B_DMA_ERR  = 28;

  localparam logic [STAT_W-1:0] CMD_ERR_M  = 32'h000F_0000;
  localparam logic [STAT_W-1:0] DATA_ERR_M = 32'h0170_0000;
  localparam logic [STAT_W-1:0] DMA_ERR_M  = 32'h1000_0000;
  localparam logic [STAT_W-1:0] CARD_INT_M = 32'h0000_0100;
  localparam logic [STAT_W-1:0] PLAIN_M    = 32'h0000_003F;
  localparam logic [STAT_W-1:0] CD_M       = 32'h0000_00C0;

  // events that may be injected by the force write
  localparam logic [STAT_W-1:0] FORCE_M = CMD_ERR_M | DATA_ERR_M | DMA_ERR_M | CARD_INT_M;
  // events accepted on evt_i
  localparam logic [STAT_W-1:0] PIN_M   = FORCE_M | PLAIN_M;
  localparam logic [STAT_W-1:0] IMPL_M  = PIN_M | CD_M;
endpackage

// File: rtl/cd_edge_sync.sv
module cd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q[0] <= lvl_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/irq_event_merge.sv
module irq_event_merge
  import irq_pkg::*;
(
  input  logic [STAT_W-1:0] evt_i,
  input  logic              force_we_i,
  input  logic [STAT_W-1:0] force_data_i,
  input  logic              cd_rise_i,
  input  logic              cd_fall_i,
  input  logic [STAT_W-1:0] stat_en_i,
  output logic [STAT_W-1:0] set_o
);
  logic [STAT_W-1:0] cd_vec, frc_vec, raw;

  always_comb begin
    cd_vec             = '0;
    cd_vec[B_CARD_INS] = cd_rise_i;
    cd_vec[B_CARD_REM] = cd_fall_i;
    frc_vec            = force_we_i ? (force_data_i & FORCE_M) : '0;
    raw                = (evt_i & PIN_M) | frc_vec | cd_vec;
    set_o              = raw & stat_en_i;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] q_o
);
  logic [STAT_W-1:0] clr_eff;

  assign clr_eff = clr_we_i ? clr_data_i : '0;

  // set applied after clear: a same-cycle event wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_eff) | set_i;
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_pkg::*;
(
  input  logic [STAT_W-1:0] status_i,
  input  logic [STAT_W-1:0] sig_en_i,
  output logic [STAT_W-1:0] masked_o,
  output logic              irq_o,
  output logic              cmd_err_o,
  output logic              data_err_o,
  output logic              any_err_o
);
  assign masked_o   = status_i & sig_en_i;
  assign irq_o      = |masked_o;
  assign cmd_err_o  = |(status_i & CMD_ERR_M);
  assign data_err_o = |(status_i & DATA_ERR_M);
  assign any_err_o  = cmd_err_o | data_err_o | status_i[B_DMA_ERR];
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              cd_i,
  input  logic [STAT_W-1:0] stat_en_i,
  input  logic [STAT_W-1:0] sig_en_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_data_i,
  input  logic              force_we_i,
  input  logic [STAT_W-1:0] force_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] masked_o,
  output logic              irq_o,
  output logic              cmd_err_o,
  output logic              data_err_o,
  output logic              any_err_o
);
  logic              cd_rise, cd_fall;
  logic [STAT_W-1:0] set_vec;

  cd_edge_sync #(.STAGES(SYNC_STAGES)) u_cd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (cd_i),
    .rise_o (cd_rise),
    .fall_o (cd_fall)
  );

  irq_event_merge u_merge (
    .evt_i        (evt_i),
    .force_we_i   (force_we_i),
    .force_data_i (force_data_i),
    .cd_rise_i    (cd_rise),
    .cd_fall_i    (cd_fall),
    .stat_en_i    (stat_en_i),
    .set_o        (set_vec)
  );

  irq_status_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .q_o        (status_o)
  );

  irq_summary u_sum (
    .status_i   (status_o),
    .sig_en_i   (sig_en_i),
    .masked_o   (masked_o),
    .irq_o      (irq_o),
    .cmd_err_o  (cmd_err_o),
    .data_err_o (data_err_o),
    .any_err_o  (any_err_o)
  );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] stat_en_i,
  input logic [STAT_W-1:0] sig_en_i,
  input logic              clr_we_i,
  input logic [STAT_W-1:0] clr_data_i,
  input logic [STAT_W-1:0] status_o,
  input logic [STAT_W-1:0] masked_o,
  input logic              irq_o,
  input logic              cmd_err_o,
  input logic              data_err_o,
  input logic              any_err_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |=> status_o == '0);

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~IMPL_M) == '0);

  // R3
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o & ~$past(status_o) & ~$past(stat_en_i)) == '0);

  // R4
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> (($past(status_o) & ~status_o) == '0));

  // R4
  clr_zero_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (($past(status_o) & ~$past(clr_data_i) & ~status_o) == '0));

  // R6
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o == (masked_o != '0)) && ((masked_o & ~status_o) == '0) && ((masked_o & ~sig_en_i) == '0));

  // R7
  any_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_err_o == (cmd_err_o | data_err_o | status_o[B_DMA_ERR]));
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stat_en_i  (stat_en_i),
  .sig_en_i   (sig_en_i),
  .clr_we_i   (clr_we_i),
  .clr_data_i (clr_data_i),
  .status_o   (status_o),
  .masked_o   (masked_o),
  .irq_o      (irq_o),
  .cmd_err_o  (cmd_err_o),
  .data_err_o (data_err_o),
  .any_err_o  (any_err_o)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  localparam logic [31:0] CMD_M   = 32'h000F_0000;
  localparam logic [31:0] DATA_M  = 32'h0170_0000;
  localparam logic [31:0] FRC_M   = 32'h117F_0100;
  localparam logic [31:0] PIN_OK  = 32'h117F_013F;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] evt = '0, stat_en = '0, sig_en = '0, clr_data = '0, force_data = '0;
  logic cd = 1'b0, clr_we = 1'b0, force_we = 1'b0;
  logic [31:0] status, masked;
  logic irq, cmd_err, data_err, any_err;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_status = '0;
  logic cs1 = 1'b0, cs2 = 1'b0, cp = 1'b0;

  always #5 clk = ~clk;

  irq_status_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .cd_i(cd),
    .stat_en_i(stat_en), .sig_en_i(sig_en), .clr_we_i(clr_we), .clr_data_i(clr_data),
    .force_we_i(force_we), .force_data_i(force_data),
    .status_o(status), .masked_o(masked), .irq_o(irq),
    .cmd_err_o(cmd_err), .data_err_o(data_err), .any_err_o(any_err)
  );

  function automatic logic [31:0] next_status(logic [31:0] cur);
    logic [31:0] s;
    s = (evt & PIN_OK) | (force_we ? (force_data & FRC_M) : 32'h0);
    s[6] = cs2 & ~cp;
    s[7] = ~cs2 & cp;
    s = s & stat_en;
    return (cur & ~(clr_we ? clr_data : 32'h0)) | s;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [31:0] em;
    em = m_status & sig_en;
    chk(req, "status", status, m_status);
    chk("R6", "masked", masked, em);
    chk("R6", "irq", {31'b0, irq}, {31'b0, em != 0});
    chk("R7", "cmd_err", {31'b0, cmd_err}, {31'b0, (m_status & CMD_M) != 0});
    chk("R7", "data_err", {31'b0, data_err}, {31'b0, (m_status & DATA_M) != 0});
    chk("R7", "any_err", {31'b0, any_err},
        {31'b0, ((m_status & (CMD_M | DATA_M)) != 0) || m_status[28]});
  endtask

  task automatic tick(string req);
    logic [31:0] nx;
    nx = next_status(m_status);
    @(posedge clk);
    m_status = nx;
    cp = cs2; cs2 = cs1; cs1 = cd;
    @(negedge clk);
    check_all(req);
    evt = '0; clr_we = 1'b0; clr_data = '0; force_we = 1'b0; force_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1 reset state
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_ni = 1'b1;
    tick("R1");

    // R3 disabled recording
    stat_en = '0; evt = '1;
    tick("R3");
    chk("R3", "disabled", status, 32'h0);
    stat_en = '1; evt = 32'h1;
    tick("R3");
    chk("R3", "enabled bit0", status, 32'h1);

    // R2 all pins, reserved and card-detect bits ignored on evt_i
    evt = '1;
    tick("R2");
    chk("R2", "pin map", status, PIN_OK);
    chk("R9", "evt bits 6,7 ignored", status & 32'hC0, 32'h0);

    // R4 zero clear keeps, partial clear
    clr_we = 1'b1; clr_data = '0;
    tick("R4");
    clr_we = 1'b1; clr_data = 32'h000F_000F;
    tick("R4");
    chk("R4", "partial clear", status, PIN_OK & ~32'h000F_000F);

    // R5 event and clear same bit
    evt = 32'h2; clr_we = 1'b1; clr_data = 32'h2;
    tick("R5");
    chk("R5", "event wins", status & 32'h2, 32'h2);
    clr_we = 1'b1; clr_data = '1;
    tick("R4");
    chk("R4", "all clear", status, 32'h0);

    // R6 signal mask
    sig_en = 32'h0000_0020; evt = 32'h0000_0030;
    tick("R6");
    chk("R6", "irq one bit", {31'b0, irq}, 32'h1);
    sig_en = 32'h0000_0001;
    #1 chk("R6", "irq masked off", {31'b0, irq}, 32'h0);
    clr_we = 1'b1; clr_data = '1;
    tick("R4");

    // R8 force
    force_we = 1'b1; force_data = '1;
    tick("R8");
    chk("R8", "force all", status, FRC_M);
    clr_we = 1'b1; clr_data = '1;
    tick("R8");
    tick("R8");
    chk("R8", "one shot", status, 32'h0);
    stat_en = 32'h0000_0100; force_we = 1'b1; force_data = '1;
    tick("R8");
    chk("R8", "force gated", status, 32'h0000_0100);
    force_data = 32'h1000_0000; force_we = 1'b0;
    tick("R8");
    stat_en = '1; clr_we = 1'b1; clr_data = '1;
    tick("R4");

    // R9 card detect edges
    cd = 1'b1;
    tick("R9");
    chk("R9", "ins edge1", status, 32'h0);
    tick("R9");
    chk("R9", "ins edge2", status, 32'h0);
    tick("R9");
    chk("R9", "ins edge3", status, 32'h40);
    cd = 1'b0;
    repeat (3) tick("R9");
    chk("R9", "removal", status, 32'hC0);
    repeat (2) tick("R9");

    // random mix
    for (int i = 0; i < 600; i++) begin
      evt        = $urandom() & $urandom();
      stat_en    = $urandom() | $urandom();
      sig_en     = $urandom();
      clr_we     = ($urandom() % 3) == 0;
      clr_data   = $urandom();
      force_we   = ($urandom() % 5) == 0;
      force_data = $urandom();
      if (($urandom() % 9) == 0) cd = ~cd;
      tick("R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule